// File: doc/BRIEF.md
# Snapshot Timekeeping Read Port

This block is the slave-side register access engine of a real-time clock that sits on a two-wire I2C bus. It watches the sampled SCL and SDA levels, detects START and STOP conditions, accepts a device-select byte and then an address/command byte, and either receives data bytes into the live time counters or sends data bytes back to the bus master.

Reads never come from the live counters. When a read command is acknowledged, the eight live bytes (seconds, minutes, hours, date, month, day, year, control) are copied into a shadow bank. Every byte sent after that comes from this frozen copy, so a multi-byte read shows one consistent moment in time while the live counters keep running. If the copy would land in a cycle where the seconds counter is being updated, it waits until the update has taken effect. Counting the time itself and the pad drivers belong to the surrounding logic: the live values and a seconds-update strobe come in as inputs, and writes go out as a one-cycle strobe with address and data.

Top module: `rtc_snap_rdport`

## Requirements
- R1: The first byte after a START is accepted and acknowledged (SDA pulled low during the ninth SCL clock) only when its bits 7:1 equal the DEV_ADDR parameter and bit 0 is 0; any other value gets no acknowledge, and the block then ignores the bus until the next START.
- R2: The second byte after a START is the command byte, taken most significant bit first; bits 7:1 form the register address and bit 0 the direction (1 = read, 0 = write). It is acknowledged only when the address is below 8 (single register, 0 = seconds ... 6 = year, 7 = control) or equals BURST_ADDR (31); otherwise no acknowledge and the bus is ignored until the next START.
- R3: On an acknowledged read command the shadow bank copies all eight live bytes in the cycle after the SCL falling edge that starts the command acknowledge; live changes after that have no effect on the bytes returned.
- R4: If sec_tick_i is high in the cycle the copy would be taken, the copy is deferred to the first cycle with sec_tick_i low, so it holds the values present after the update.
- R5: A single read returns the addressed shadow byte, MSB first, then releases SDA for the rest of the transfer whether the master acknowledges or not (further bytes read as 0xFF).
- R6: A burst read returns shadow bytes in the order seconds, minutes, hours, date, month, day, year, control, advancing after each byte the master acknowledges; after a master NACK or after the control byte, SDA is released (further bytes read as 0xFF).
- R7: In a write transfer each accepted data byte is acknowledged and produces exactly one wr_en_o pulse, carrying wr_addr_o and wr_data_o, right after the SCL falling edge that starts its acknowledge; a single write accepts one byte, a burst write accepts bytes for addresses 0 to 7 in turn, and any further byte is not acknowledged and produces no pulse.
- R8: sda_oe_o never changes while SCL stays high.
- R9: A STOP returns the block to idle, so a byte sent without a new START is not acknowledged; a repeated START at a byte boundary restarts device-select reception.
- R10: After reset sda_oe_o and wr_en_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA bus level |
| sec_tick_i | input | 1 | High in the cycle the live counters take a new second |
| live_i | input | N_REGS*8 | Live register bytes, byte k at bits 8k+7:8k |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | $clog2(N_REGS) | Register address of the write |
| wr_data_o | output | 8 | Data byte of the write |

## Verification
The bench attacks the copy timing: live values are changed just after the command acknowledge, so a design that read the live bank directly would return the new pattern, and in a second case the seconds strobe is held across the capture edge so a design without the guard returns the stale values. Every burst length from one to eight bytes is ended by a NACK to catch an off-by-one pointer or a slave that keeps driving after the master declined, and every one of the 128 device and command addresses is swept to catch a loose address decode. Single and burst writes check that the strobe count and address are exact and that a byte past the end is refused rather than wrapped.

// File: rtl/rtcrd_pkg.sv
package rtcrd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_CMD,
        ST_WDAT,
        ST_RDAT,
        ST_HALT
    } xfer_st_e;
endpackage

// File: rtl/rtcrd_bus_edges.sv
module rtcrd_bus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } lvl_t;

    lvl_t lvl_d, lvl_q;

    always_comb begin
        lvl_d.scl = scl_i;
        lvl_d.sda = sda_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign scl_rise_o = !lvl_q.scl && scl_i;
    assign scl_fall_o = lvl_q.scl && !scl_i;
    assign start_o    = lvl_q.scl && scl_i && lvl_q.sda && !sda_i;
    assign stop_o     = lvl_q.scl && scl_i && !lvl_q.sda && sda_i;
endmodule

// File: rtl/rtcrd_snapshot.sv
module rtcrd_snapshot #(
    parameter int N_REGS = 8,
    localparam int SW    = N_REGS * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [SW-1:0] live_i,
    output logic [SW-1:0] shadow_o
);
    typedef struct packed {
        logic          pend;
        logic [SW-1:0] bank;
    } snap_t;

    snap_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (clr_i) begin
            snap_d.pend = 1'b0;
        end else if ((req_i || snap_q.pend) && !tick_i) begin
            snap_d.bank = live_i;
            snap_d.pend = 1'b0;
        end else if (req_i) begin
            snap_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    assign shadow_o = snap_q.bank;

    AST_HOLD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> $stable(shadow_o)) else $error("shadow moved in a tick cycle"); // R4
    AST_DEFER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i || snap_q.pend) && tick_i && !clr_i) |=> snap_q.pend) else $error("deferred copy lost"); // R4
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && !snap_q.pend) |=> $stable(shadow_o)) else $error("shadow moved without request"); // R3
endmodule

// File: rtl/rtcrd_xfer_fsm.sv
module rtcrd_xfer_fsm
    import rtcrd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h68,
    parameter int         N_REGS     = 8,
    parameter logic [6:0] BURST_ADDR = 7'h1F,
    localparam int        AW         = $clog2(N_REGS),
    localparam int        SW         = N_REGS * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          sda_i,
    input  logic [SW-1:0] shadow_i,
    output logic          sda_oe_o,
    output logic          cap_req_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o
);
    localparam logic [6:0]    NREG7 = 7'(N_REGS);
    localparam logic [AW-1:0] LAST  = AW'(N_REGS - 1);

    typedef struct packed {
        xfer_st_e      st;
        logic [3:0]    bitcnt;
        logic [7:0]    sh;
        logic [AW-1:0] ptr;
        logic          burst;
        logic          rd;
        logic          ack;
        logic          m_ack;
        logic          oe;
        logic          wr_en;
        logic [AW-1:0] wr_addr;
        logic [7:0]    wr_data;
    } fsm_t;

    fsm_t f_d, f_q;

    logic          cap;
    logic          active;
    logic          cmd_ok;
    logic [AW-1:0] ptr_inc;
    logic [7:0]    cur_byte;
    logic [7:0]    nxt_byte;

    always_comb begin
        f_d      = f_q;
        f_d.wr_en = 1'b0;
        cap      = 1'b0;
        cmd_ok   = 1'b0;
        ptr_inc  = f_q.ptr + 1'b1;
        cur_byte = shadow_i[{f_q.ptr, 3'b000} +: 8];
        nxt_byte = shadow_i[{ptr_inc, 3'b000} +: 8];
        active   = (f_q.st == ST_DEV) || (f_q.st == ST_CMD) ||
                   (f_q.st == ST_WDAT) || (f_q.st == ST_RDAT);

        if (stop_i) begin
            f_d.st     = ST_IDLE;
            f_d.oe     = 1'b0;
            f_d.bitcnt = '0;
        end else if (start_i) begin
            f_d.st     = ST_DEV;
            f_d.oe     = 1'b0;
            f_d.bitcnt = '0;
        end else if (active && rise_i) begin
            if (f_q.bitcnt < 4'd8) f_d.sh = {f_q.sh[6:0], sda_i};
            if (f_q.bitcnt == 4'd8) f_d.m_ack = !sda_i;
            if (f_q.bitcnt < 4'd9) f_d.bitcnt = f_q.bitcnt + 4'd1;
        end else if (active && fall_i) begin
            if (f_q.bitcnt == 4'd8) begin
                case (f_q.st)
                    ST_DEV: f_d.ack = (f_q.sh[7:1] == DEV_ADDR) && !f_q.sh[0];
                    ST_CMD: begin
                        cmd_ok    = (f_q.sh[7:1] < NREG7) || (f_q.sh[7:1] == BURST_ADDR);
                        f_d.ack   = cmd_ok;
                        f_d.burst = (f_q.sh[7:1] == BURST_ADDR);
                        f_d.rd    = f_q.sh[0];
                        f_d.ptr   = f_d.burst ? '0 : f_q.sh[AW:1];
                        cap       = cmd_ok && f_q.sh[0];
                    end
                    ST_WDAT: begin
                        f_d.ack     = 1'b1;
                        f_d.wr_en   = 1'b1;
                        f_d.wr_addr = f_q.ptr;
                        f_d.wr_data = f_q.sh;
                    end
                    default: f_d.ack = 1'b0;
                endcase
                f_d.oe = f_d.ack;
            end else if (f_q.bitcnt == 4'd9) begin
                f_d.bitcnt = '0;
                f_d.oe     = 1'b0;
                case (f_q.st)
                    ST_DEV: f_d.st = f_q.ack ? ST_CMD : ST_HALT;
                    ST_CMD: begin
                        if (!f_q.ack) begin
                            f_d.st = ST_HALT;
                        end else if (f_q.rd) begin
                            f_d.st = ST_RDAT;
                            f_d.oe = !cur_byte[7];
                        end else begin
                            f_d.st = ST_WDAT;
                        end
                    end
                    ST_WDAT: begin
                        if (f_q.burst && f_q.ptr != LAST) f_d.ptr = ptr_inc;
                        else f_d.st = ST_HALT;
                    end
                    default: begin
                        if (f_q.burst && f_q.m_ack && f_q.ptr != LAST) begin
                            f_d.ptr = ptr_inc;
                            f_d.oe  = !nxt_byte[7];
                        end else begin
                            f_d.st = ST_HALT;
                        end
                    end
                endcase
            end else if (f_q.st == ST_RDAT && f_q.bitcnt != 4'd0) begin
                f_d.oe = !cur_byte[3'd7 - f_q.bitcnt[2:0]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q    <= '0;
            f_q.st <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign sda_oe_o  = f_q.oe;
    assign cap_req_o = cap;
    assign wr_en_o   = f_q.wr_en;
    assign wr_addr_o = f_q.wr_addr;
    assign wr_data_o = f_q.wr_data;

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o) else $error("write strobe longer than one cycle"); // R7
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_HALT || f_q.st == ST_IDLE) |-> !sda_oe_o) else $error("driving SDA while off the bus"); // R9
    AST_CAP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req_o |=> (sda_oe_o && f_q.st == ST_CMD)) else $error("copy without acknowledged command"); // R3
endmodule

// File: rtl/rtc_snap_rdport.sv
module rtc_snap_rdport #(
    parameter logic [6:0] DEV_ADDR   = 7'h68,
    parameter int         N_REGS     = 8,
    parameter logic [6:0] BURST_ADDR = 7'h1F,
    localparam int        AW         = $clog2(N_REGS),
    localparam int        SW         = N_REGS * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          sec_tick_i,
    input  logic [SW-1:0] live_i,
    output logic          sda_oe_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o
);
    logic          scl_rise, scl_fall, bus_start, bus_stop;
    logic          cap_req;
    logic [SW-1:0] shadow;

    rtcrd_bus_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    rtcrd_snapshot #(.N_REGS(N_REGS)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (cap_req),
        .clr_i    (bus_stop),
        .tick_i   (sec_tick_i),
        .live_i   (live_i),
        .shadow_o (shadow)
    );

    rtcrd_xfer_fsm #(
        .DEV_ADDR   (DEV_ADDR),
        .N_REGS     (N_REGS),
        .BURST_ADDR (BURST_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (scl_rise),
        .fall_i    (scl_fall),
        .start_i   (bus_start),
        .stop_i    (bus_stop),
        .sda_i     (sda_i),
        .shadow_i  (shadow),
        .sda_oe_o  (sda_oe_o),
        .cap_req_o (cap_req),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o)
    );

    AST_SDA_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe_o)) else $error("SDA drive changed with SCL high"); // R8
endmodule

// File: tb/tb_rtc_snap_rdport.sv
module tb_rtc_snap_rdport;
    localparam int         CLK_NS = 10;
    localparam int         HP     = 4;
    localparam logic [6:0] DEV    = 7'h68;
    localparam logic [6:0] BURST  = 7'h1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sec_tick = 1'b0;
    logic [63:0] live = '0;
    logic        sda_oe;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        sda_bus;

    int n_chk = 0;
    int n_bad = 0;
    int wn = 0;
    int sda_viol = 0;
    bit done = 1'b0;
    logic [2:0] wl_a [0:63];
    logic [7:0] wl_d [0:63];

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_NS/2) clk = ~clk;

    rtc_snap_rdport #(.DEV_ADDR(DEV), .N_REGS(8), .BURST_ADDR(BURST)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sec_tick_i (sec_tick),
        .live_i     (live),
        .sda_oe_o   (sda_oe),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    logic prev_scl = 1'b1;
    logic prev_oe  = 1'b0;
    always @(negedge clk) begin
        if (wr_en && wn < 64) begin
            wl_a[wn] = wr_addr;
            wl_d[wn] = wr_data;
        end
        if (wr_en) wn = wn + 1;
        if (rst_n && scl_m && prev_scl && sda_oe != prev_oe) sda_viol = sda_viol + 1;
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    function automatic logic [7:0] pat(int seed, int k);
        return 8'((seed * 37 + k * 11 + 5) & 255);
    endfunction

    function automatic logic [63:0] fill(int seed);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = pat(seed, k);
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tk(1); scl_m = 1'b1; tk(HP);
        sda_m = 1'b0; tk(HP);
        scl_m = 1'b0; tk(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tk(HP);
        scl_m = 1'b1; tk(HP);
        sda_m = 1'b1; tk(HP);
    endtask

    task automatic put_byte(input logic [7:0] b, input bit hook, output bit ack,
                            input logic [63:0] hook_live);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tk(HP);
            scl_m = 1'b1; tk(HP);
            scl_m = 1'b0; tk(1);
        end
        if (hook) begin
            tk(2);
            live     = hook_live;
            sec_tick = 1'b0;
        end
        sda_m = 1'b1; tk(HP);
        scl_m = 1'b1; tk(HP/2);
        ack = !sda_bus; tk(HP/2);
        scl_m = 1'b0; tk(1);
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tk(HP);
            scl_m = 1'b1; tk(HP/2);
            b[i] = sda_bus; tk(HP/2);
            scl_m = 1'b0; tk(1);
        end
        sda_m = !mack; tk(HP);
        scl_m = 1'b1; tk(HP);
        scl_m = 1'b0; tk(1);
        sda_m = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        bit ack;
        logic [7:0] b;
        int base;

        tk(4);
        check("R10 oe after reset", 32'(sda_oe), 0);
        check("R10 wr_en after reset", 32'(wr_en), 0);
        rst_n = 1'b1;
        tk(4);

        // R1: sweep every device address, write direction, plus matching address with read bit
        for (int a = 0; a < 128; a++) begin
            bus_start();
            put_byte({7'(a), 1'b0}, 1'b0, ack, '0);
            check("R1 device select ack", 32'(ack), 32'(7'(a) == DEV));
            bus_stop();
        end
        bus_start();
        put_byte({DEV, 1'b1}, 1'b0, ack, '0);
        check("R1 read bit in device byte", 32'(ack), 0);
        bus_stop();

        // R2: sweep every command address (write direction)
        for (int a = 0; a < 128; a++) begin
            bus_start();
            put_byte({DEV, 1'b0}, 1'b0, ack, '0);
            put_byte({7'(a), 1'b0}, 1'b0, ack, '0);
            check("R2 command ack", 32'(ack), 32'((a < 8) || (7'(a) == BURST)));
            bus_stop();
        end

        // R3 / R5: single reads of each register; live changes after the command ack
        for (int a = 0; a < 8; a++) begin
            live = fill(a);
            bus_start();
            put_byte({DEV, 1'b0}, 1'b0, ack, '0);
            put_byte({7'(a), 1'b1}, 1'b0, ack, '0);
            check("R2 read command ack", 32'(ack), 1);
            live = fill(a + 50);
            get_byte(1'b1, b);
            check("R3 R5 single read data from copy", 32'(b), 32'(pat(a, a)));
            get_byte(1'b0, b);
            check("R5 released after single read", 32'(b), 32'hFF);
            bus_stop();
        end

        // R6: burst reads ended by NACK after every length
        for (int k = 1; k <= 8; k++) begin
            live = fill(k + 10);
            bus_start();
            put_byte({DEV, 1'b0}, 1'b0, ack, '0);
            put_byte({BURST, 1'b1}, 1'b0, ack, '0);
            live = fill(k + 90);
            for (int j = 0; j < k; j++) begin
                get_byte((j < k - 1) || (k == 8), b);
                check("R6 burst byte order", 32'(b), 32'(pat(k + 10, j)));
            end
            get_byte(1'b0, b);
            check("R6 released after burst end", 32'(b), 32'hFF);
            bus_stop();
        end

        // R4: seconds update held across the capture edge
        live = fill(200);
        sec_tick = 1'b1;
        bus_start();
        put_byte({DEV, 1'b0}, 1'b0, ack, '0);
        put_byte({BURST, 1'b1}, 1'b1, ack, fill(201));
        live = fill(202);
        for (int j = 0; j < 8; j++) begin
            get_byte(1'b1, b);
            check("R4 deferred copy holds updated values", 32'(b), 32'(pat(201, j)));
        end
        get_byte(1'b0, b);
        check("R6 nothing after control byte", 32'(b), 32'hFF);
        bus_stop();

        // R7: single writes
        for (int a = 0; a < 8; a++) begin
            base = wn;
            bus_start();
            put_byte({DEV, 1'b0}, 1'b0, ack, '0);
            put_byte({7'(a), 1'b0}, 1'b0, ack, '0);
            put_byte(pat(77, a), 1'b0, ack, '0);
            check("R7 single write data ack", 32'(ack), 1);
            put_byte(8'h5A, 1'b0, ack, '0);
            check("R7 second byte refused", 32'(ack), 0);
            bus_stop();
            check("R7 single write strobe count", 32'(wn - base), 1);
            check("R7 single write address", 32'(wl_a[base]), 32'(a));
            check("R7 single write data", 32'(wl_d[base]), 32'(pat(77, a)));
        end

        // R7: burst write over the whole group
        base = wn;
        bus_start();
        put_byte({DEV, 1'b0}, 1'b0, ack, '0);
        put_byte({BURST, 1'b0}, 1'b0, ack, '0);
        for (int j = 0; j < 8; j++) begin
            put_byte(pat(33, j), 1'b0, ack, '0);
            check("R7 burst write ack", 32'(ack), 1);
        end
        put_byte(8'hC3, 1'b0, ack, '0);
        check("R7 byte past group refused", 32'(ack), 0);
        bus_stop();
        check("R7 burst write strobe count", 32'(wn - base), 8);
        for (int j = 0; j < 8; j++) begin
            check("R7 burst write address", 32'(wl_a[base + j]), 32'(j));
            check("R7 burst write data", 32'(wl_d[base + j]), 32'(pat(33, j)));
        end

        // R9: no START after STOP, then repeated START
        put_byte({DEV, 1'b0}, 1'b0, ack, '0);
        check("R9 byte without START ignored", 32'(ack), 0);
        bus_stop();
        live = fill(120);
        bus_start();
        put_byte({DEV, 1'b0}, 1'b0, ack, '0);
        put_byte({7'd2, 1'b0}, 1'b0, ack, '0);
        bus_start();
        put_byte({DEV, 1'b0}, 1'b0, ack, '0);
        check("R9 repeated START device ack", 32'(ack), 1);
        put_byte({BURST, 1'b1}, 1'b0, ack, '0);
        get_byte(1'b0, b);
        check("R9 burst after repeated START", 32'(b), 32'(pat(120, 0)));
        get_byte(1'b0, b);
        check("R6 released after NACK", 32'(b), 32'hFF);
        bus_stop();

        check("R8 SDA drive steady while SCL high", 32'(sda_viol), 0);

        done = 1'b1;
        finish_run();
    end
endmodule